// File: doc/BRIEF.md
# Configurable Serial Register Port

This block is a synchronous serial slave that lets a host read and write a small file of byte registers. The bus has a serial clock, an active-low chip select, a bidirectional data line (`sdio_i`, `sdio_o` and `sdio_oe`) and a separate output line (`sdo`, `sdo_oe`). All bus inputs pass through a synchronizer into the system clock domain. Their edges are detected there, so every piece of state is clocked by `clk`. Input bits are captured on serial-clock rising edges. Output bits are updated on falling edges.

Each transfer starts with an instruction byte:

- bit 7: 1 means read, 0 means write.
- bits 6:5: byte count minus one.
- bits 4:0: start address.

Data bytes follow the instruction. Addresses 0 and 1 hold the 16-bit control word, low byte first. Address 0 bit 0 selects the wiring, bit 1 the bit order and bit 2 the address direction. Addresses 2 up to `NUM_BYTES-1` are plain storage bytes. The control word is also presented on `ctrl_word` for the rest of the chip.

The wiring, bit order and address direction are read from the control word when chip select falls. They then stay fixed until the transfer ends. A transfer that changes them therefore finishes under its old settings.

Top module: `serial_reg_port`

## Requirements
- R1: After reset, `ctrl_word` is 0 and both `sdio_oe` and `sdo_oe` are low.
- R2: An instruction byte has read/write in bit 7 (1 = read), count-1 in bits 6:5 and the start address in bits 4:0. A write stores each data byte at its address, and a read returns it.
- R3: With control bit 1 low, the instruction and data bytes move most significant bit first in both directions.
- R4: With control bit 1 high, the instruction and data bytes move least significant bit first in both directions.
- R5: With control bit 2 low, each further byte of a transfer goes to the next lower address (5-bit wrap).
- R6: With control bit 2 high, each further byte of a transfer goes to the next higher address.
- R7: With control bit 0 low, read data leaves on `sdio_o`. `sdio_oe` is high only during the data bytes of a read, and `sdo_oe` stays low.
- R8: With control bit 0 high, read data leaves on `sdo` with `sdo_oe` high during the data bytes, and `sdio_oe` never asserts.
- R9: Control bits 15:13 always read as zero; writes of ones to them are dropped.
- R10: Changes to control bits 2:0 written during a transfer apply only from the next chip-select fall.
- R11: Raising chip select in the middle of a byte abandons it. Nothing is written, the output enables drop, and the next transfer begins again with an instruction byte.
- R12: Bytes beyond the instruction's count are ignored. Writes to addresses at or above `NUM_BYTES` are dropped, and reads there return 0.
- R13: `ctrl_word` shows the control word, with address 0 as bits 7:0 and address 1 as bits 15:8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Chip select, active low |
| sdio_i | input | 1 | Serial data in from the shared line |
| sdio_o | output | 1 | Serial data out on the shared line (two-wire) |
| sdio_oe | output | 1 | Drive enable for the shared line |
| sdo | output | 1 | Serial data out on the dedicated line (three-wire) |
| sdo_oe | output | 1 | Drive enable for the dedicated line |
| ctrl_word | output | 16 | Current control word |

## Verification
The bench uses the defaults: `NUM_BYTES` = 8, a 5-bit address, a 2-bit count field and two synchronizer stages. With only eight storage bytes, an address such as 9 lies outside the file, so the dropped-write and zero-read cases can be reached. Reads at address 0 and 1 exercise the control word. The four-byte count field covers transfers that step up and down from a mid-range address. The serial clock runs at one sixteenth of the system clock, which leaves room for the synchronizer and edge-detect latency between each serial edge and the bench's sampling point.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int BYTE_W = 8;

  // positions of the mode bits inside the low control byte
  localparam int MODE_WIRE_BIT  = 0;
  localparam int MODE_ORDER_BIT = 1;
  localparam int MODE_DIR_BIT   = 2;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_INSTR = 2'd1,
    PH_DATA  = 2'd2,
    PH_DONE  = 2'd3
  } phase_t;

  typedef struct packed {
    logic ascend;
    logic lsb_first;
    logic three_wire;
  } xfer_mode_t;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int              WIDTH     = 3,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= RESET_VAL;
          else     pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= RESET_VAL;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile #(
  parameter int ADDR_W    = 5,
  parameter int NUM_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [15:0]       ctrl_word
);
  localparam int               IDX_W     = $clog2(NUM_BYTES);
  localparam logic [ADDR_W:0]  LIMIT     = (ADDR_W+1)'(NUM_BYTES);
  localparam logic [7:0]       HI_KEEP   = 8'h1F;   // bits 15:13 forced low

  logic [7:0] ctrl_lo, ctrl_hi;
  logic [7:0] store [NUM_BYTES];

  logic wr_in_range, rd_in_range;
  assign wr_in_range = ({1'b0, wr_addr} < LIMIT);
  assign rd_in_range = ({1'b0, rd_addr} < LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_lo <= '0;
      ctrl_hi <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(0)) ctrl_lo <= wr_data;
      if (wr_addr == ADDR_W'(1)) ctrl_hi <= wr_data & HI_KEEP;
    end
  end

  // storage bytes carry no reset so they map onto distributed/block RAM
  always_ff @(posedge clk) begin
    if (wr_en && wr_in_range && wr_addr > ADDR_W'(1))
      store[wr_addr[IDX_W-1:0]] <= wr_data;
  end

  always_comb begin
    if (rd_addr == ADDR_W'(0))      rd_data = ctrl_lo;
    else if (rd_addr == ADDR_W'(1)) rd_data = ctrl_hi;
    else if (rd_in_range)           rd_data = store[rd_addr[IDX_W-1:0]];
    else                            rd_data = '0;
  end

  assign ctrl_word = {ctrl_hi, ctrl_lo};

  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (rst)
    ctrl_hi[7:5] == 3'b000);

  p_low_byte_lands_r13: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(0)) |=> (ctrl_word[7:0] == $past(wr_data)));
endmodule

// File: rtl/srp_engine.sv
module srp_engine
  import srp_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              din_s,
  input  xfer_mode_t        mode_in,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic              sdo,
  output logic              sdo_oe
);
  // instruction layout: [7] read, [ADDR_W +: CNT_W] count-1, [ADDR_W-1:0] address
  localparam int RD_BIT = BYTE_W - 1;

  phase_t            phase;
  xfer_mode_t        mode;
  logic [2:0]        bit_cnt;
  logic [7:0]        in_sh, out_sh;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  left;
  logic              is_rd;
  logic              sclk_d;

  logic              rise, fall, active, last_bit;
  logic [7:0]        sh_next;
  logic [ADDR_W-1:0] addr_step;

  assign rise      = sclk_s & ~sclk_d;
  assign fall      = ~sclk_s & sclk_d;
  assign active    = (phase == PH_INSTR) || (phase == PH_DATA);
  assign last_bit  = (bit_cnt == 3'd7);
  assign sh_next   = mode.lsb_first ? {din_s, in_sh[7:1]} : {in_sh[6:0], din_s};
  assign addr_step = mode.ascend ? addr + ADDR_W'(1) : addr - ADDR_W'(1);
  assign rd_addr   = (phase == PH_INSTR) ? sh_next[ADDR_W-1:0] : addr_step;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      mode    <= '0;
      bit_cnt <= '0;
      in_sh   <= '0;
      out_sh  <= '0;
      addr    <= '0;
      left    <= '0;
      is_rd   <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      sdio_o  <= 1'b0;
      sdio_oe <= 1'b0;
      sdo     <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (cs_n_s) begin
        phase   <= PH_IDLE;
        bit_cnt <= '0;
        sdio_oe <= 1'b0;
        sdo_oe  <= 1'b0;
      end else if (phase == PH_IDLE) begin
        phase   <= PH_INSTR;
        mode    <= mode_in;
        bit_cnt <= '0;
        is_rd   <= 1'b0;
      end else begin
        if (rise && active) begin
          in_sh   <= sh_next;
          bit_cnt <= bit_cnt + 3'd1;
          if (last_bit) begin
            if (phase == PH_INSTR) begin
              phase <= PH_DATA;
              addr  <= sh_next[ADDR_W-1:0];
              left  <= sh_next[ADDR_W +: CNT_W];
              is_rd <= sh_next[RD_BIT];
              if (sh_next[RD_BIT]) begin
                out_sh  <= rd_data;
                sdio_oe <= ~mode.three_wire;
                sdo_oe  <= mode.three_wire;
              end
            end else begin
              if (is_rd) begin
                out_sh <= rd_data;
              end else begin
                wr_en   <= 1'b1;
                wr_addr <= addr;
                wr_data <= sh_next;
              end
              addr <= addr_step;
              if (left == '0) begin
                phase   <= PH_DONE;
                sdio_oe <= 1'b0;
                sdo_oe  <= 1'b0;
              end else begin
                left <= left - CNT_W'(1);
              end
            end
          end
        end
        if (fall && phase == PH_DATA && is_rd) begin
          if (mode.lsb_first) begin
            sdio_o <= mode.three_wire ? 1'b0 : out_sh[0];
            sdo    <= mode.three_wire ? out_sh[0] : 1'b0;
            out_sh <= {1'b0, out_sh[7:1]};
          end else begin
            sdio_o <= mode.three_wire ? 1'b0 : out_sh[7];
            sdo    <= mode.three_wire ? out_sh[7] : 1'b0;
            out_sh <= {out_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  p_oe_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(sdio_oe && sdo_oe));

  p_three_wire_shared_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && mode.three_wire) |-> !sdio_oe);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> (!sdio_oe && !sdo_oe));

  p_mode_held_r10: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(mode));

  p_write_from_data_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (!is_rd && $past(phase) == PH_DATA));

  p_abort_clears_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_s) |=> (phase == PH_IDLE && bit_cnt == 3'd0));
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srp_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int CNT_W       = 2,
  parameter int NUM_BYTES   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        sdio_i,
  output logic        sdio_o,
  output logic        sdio_oe,
  output logic        sdo,
  output logic        sdo_oe,
  output logic [15:0] ctrl_word
);
  logic [2:0]        sync_q;
  logic              cs_n_s, sclk_s, din_s;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [7:0]        wr_data, rd_data;
  xfer_mode_t        mode_now;

  srp_sync #(
    .WIDTH     (3),
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (3'b100)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, sclk, sdio_i}),
    .q   (sync_q)
  );

  assign {cs_n_s, sclk_s, din_s} = sync_q;

  assign mode_now.ascend     = ctrl_word[MODE_DIR_BIT];
  assign mode_now.lsb_first  = ctrl_word[MODE_ORDER_BIT];
  assign mode_now.three_wire = ctrl_word[MODE_WIRE_BIT];

  srp_engine #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_engine (
    .clk     (clk),
    .rst     (rst),
    .cs_n_s  (cs_n_s),
    .sclk_s  (sclk_s),
    .din_s   (din_s),
    .mode_in (mode_now),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .sdio_o  (sdio_o),
    .sdio_oe (sdio_oe),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe)
  );

  srp_regfile #(
    .ADDR_W    (ADDR_W),
    .NUM_BYTES (NUM_BYTES)
  ) u_regfile (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .ctrl_word (ctrl_word)
  );
endmodule

// File: tb/serial_reg_port_bench.sv
`timescale 1ns/1ps
module serial_reg_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdio_i = 1'b0;
  logic        sdio_o, sdio_oe, sdo, sdo_oe;
  logic [15:0] ctrl_word;

  int checks = 0;
  int failures = 0;

  // bench-side view of the mode in force for the next transfer
  bit bm_lsb = 0;
  bit bm_three = 0;

  logic [7:0] tx [4];
  logic [7:0] rx [4];
  bit instr_oe_any, d_sdio_all, d_sdio_any, d_sdo_all, d_sdo_any;

  always #2 clk = ~clk;

  serial_reg_port u_serial_reg_port (
    .clk       (clk),
    .rst       (rst),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .sdio_i    (sdio_i),
    .sdio_o    (sdio_o),
    .sdio_oe   (sdio_oe),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .ctrl_word (ctrl_word)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one byte each way; returns what was seen on the active output line
  task automatic xbyte(input logic [7:0] b, output logic [7:0] got,
                       output bit sdio_all, output bit sdio_any,
                       output bit sdo_all, output bit sdo_any);
    got = '0; sdio_all = 1; sdio_any = 0; sdo_all = 1; sdo_any = 0;
    for (int i = 0; i < 8; i++) begin
      int k;
      k = bm_lsb ? i : 7 - i;
      sdio_i = b[k];
      tick(8);
      got[k] = bm_three ? sdo : sdio_o;
      sdio_all = sdio_all & sdio_oe;  sdio_any = sdio_any | sdio_oe;
      sdo_all  = sdo_all & sdo_oe;    sdo_any  = sdo_any | sdo_oe;
      sclk = 1'b1;
      tick(8);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input bit rd, input int n, input logic [4:0] addr, input int nsend);
    logic [7:0] g;
    bit a1, a2, a3, a4;
    cs_n = 1'b0;
    tick(8);
    xbyte({rd, 2'(n - 1), addr}, g, a1, a2, a3, a4);
    instr_oe_any = a2 | a4;
    d_sdio_all = 1; d_sdio_any = 0; d_sdo_all = 1; d_sdo_any = 0;
    for (int i = 0; i < nsend; i++) begin
      xbyte(rd ? 8'h00 : tx[i], g, a1, a2, a3, a4);
      rx[i] = g;
      d_sdio_all &= a1; d_sdio_any |= a2; d_sdo_all &= a3; d_sdo_any |= a4;
    end
    tick(4);
    cs_n = 1'b1;
    tick(16);
  endtask

  task automatic wr1(input logic [4:0] addr, input logic [7:0] v);
    tx[0] = v;
    xfer(1'b0, 1, addr, 1);
  endtask

  task automatic rd1(input logic [4:0] addr, output logic [7:0] v);
    xfer(1'b1, 1, addr, 1);
    v = rx[0];
  endtask

  task automatic t_reset;
    chk(ctrl_word == 16'h0, "R1 ctrl_word after reset", 32'(ctrl_word), 0);
    chk(!sdio_oe && !sdo_oe, "R1 enables after reset", {sdio_oe, sdo_oe}, 0);
  endtask

  task automatic t_single;
    logic [7:0] v;
    wr1(5'd3, 8'hA5);
    rd1(5'd3, v);
    chk(v == 8'hA5, "R2 R3 single byte round trip msb-first", 32'(v), 32'hA5);
  endtask

  task automatic t_two_wire;
    xfer(1'b1, 1, 5'd3, 1);
    chk(!instr_oe_any, "R7 shared enable low during instruction", 32'(instr_oe_any), 0);
    chk(d_sdio_all && !d_sdo_any, "R7 shared enable during read data only", {d_sdio_all, d_sdo_any}, 2);
    chk(!sdio_oe, "R7 shared enable released after transfer", 32'(sdio_oe), 0);
  endtask

  task automatic t_descend;
    logic [7:0] v;
    tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33;
    xfer(1'b0, 3, 5'd5, 3);
    rd1(5'd4, v);
    chk(v == 8'h22, "R5 second byte at address 4", 32'(v), 32'h22);
    rd1(5'd3, v);
    chk(v == 8'h33, "R5 third byte at address 3", 32'(v), 32'h33);
    xfer(1'b1, 3, 5'd5, 3);
    chk(rx[0] == 8'h11 && rx[1] == 8'h22 && rx[2] == 8'h33, "R5 descending burst read",
        {8'h0, rx[0], rx[1], rx[2]}, 32'h112233);
  endtask

  task automatic t_extra;
    logic [7:0] v;
    wr1(5'd2, 8'h5A);
    tx[0] = 8'h3C; tx[1] = 8'h99;
    xfer(1'b0, 1, 5'd3, 2);
    rd1(5'd2, v);
    chk(v == 8'h5A, "R12 byte past count ignored", 32'(v), 32'h5A);
    rd1(5'd3, v);
    chk(v == 8'h3C, "R12 counted byte stored", 32'(v), 32'h3C);
    wr1(5'd9, 8'hEE);
    rd1(5'd9, v);
    chk(v == 8'h00, "R12 out-of-range address reads zero", 32'(v), 0);
  endtask

  task automatic t_ascend;
    logic [7:0] v;
    wr1(5'd0, 8'h04);
    bm_lsb = 0; bm_three = 0;
    tx[0] = 8'h41; tx[1] = 8'h42; tx[2] = 8'h43;
    xfer(1'b0, 3, 5'd4, 3);
    rd1(5'd6, v);
    chk(v == 8'h43, "R6 third byte at address 6", 32'(v), 32'h43);
    xfer(1'b1, 3, 5'd4, 3);
    chk(rx[0] == 8'h41 && rx[1] == 8'h42 && rx[2] == 8'h43, "R6 ascending burst read",
        {8'h0, rx[0], rx[1], rx[2]}, 32'h414243);
    wr1(5'd0, 8'h00);
  endtask

  task automatic t_reserved;
    logic [7:0] v;
    tx[0] = 8'hFF; tx[1] = 8'h00;
    xfer(1'b0, 2, 5'd1, 2);
    chk(ctrl_word == 16'h1F00, "R9 R13 reserved bits stay zero", 32'(ctrl_word), 32'h1F00);
    rd1(5'd1, v);
    chk(v == 8'h1F, "R9 reserved bits read zero", 32'(v), 32'h1F);
    wr1(5'd1, 8'h00);
    chk(ctrl_word == 16'h0, "R13 high byte cleared", 32'(ctrl_word), 0);
  endtask

  task automatic t_lsb;
    logic [7:0] v;
    wr1(5'd0, 8'h02);
    bm_lsb = 1;
    chk(ctrl_word == 16'h0002, "R13 order bit visible", 32'(ctrl_word), 2);
    wr1(5'd6, 8'h1E);
    rd1(5'd6, v);
    chk(v == 8'h1E, "R4 lsb-first round trip", 32'(v), 32'h1E);
    rd1(5'd0, v);
    chk(v == 8'h02, "R4 lsb-first control read", 32'(v), 2);
    wr1(5'd0, 8'h00);
    chk(ctrl_word == 16'h0, "R4 lsb-first instruction decoded", 32'(ctrl_word), 0);
    bm_lsb = 0;
    rd1(5'd6, v);
    chk(v == 8'h1E, "R3 msb-first read of lsb-written byte", 32'(v), 32'h1E);
  endtask

  task automatic t_three;
    wr1(5'd0, 8'h01);
    bm_three = 1;
    xfer(1'b1, 1, 5'd6, 1);
    chk(rx[0] == 8'h1E, "R8 data on dedicated line", 32'(rx[0]), 32'h1E);
    chk(d_sdo_all && !d_sdio_any && !instr_oe_any, "R8 enables in three-wire",
        {d_sdo_all, d_sdio_any, instr_oe_any}, 4);
    wr1(5'd0, 8'h00);
    bm_three = 0;
    chk(ctrl_word == 16'h0, "R8 back to two-wire", 32'(ctrl_word), 0);
  endtask

  task automatic t_next_xfer;
    wr1(5'd0, 8'h04);
    tx[0] = 8'h06; tx[1] = 8'h01;
    xfer(1'b0, 2, 5'd0, 2);
    chk(ctrl_word == 16'h0106, "R10 old mode kept within transfer", 32'(ctrl_word), 32'h0106);
    bm_lsb = 1;
    tx[0] = 8'h00; tx[1] = 8'h00;
    xfer(1'b0, 2, 5'd0, 2);
    bm_lsb = 0;
    chk(ctrl_word == 16'h0, "R10 new mode used by next transfer", 32'(ctrl_word), 0);
  endtask

  task automatic t_abort;
    logic [7:0] v;
    cs_n = 1'b0;
    tick(8);
    for (int i = 0; i < 4; i++) begin
      sdio_i = 1'b1;
      tick(8); sclk = 1'b1; tick(8); sclk = 1'b0;
    end
    cs_n = 1'b1;
    tick(16);
    chk(!sdio_oe && !sdo_oe, "R11 enables low after abort", {sdio_oe, sdo_oe}, 0);
    wr1(5'd7, 8'h77);
    rd1(5'd7, v);
    chk(v == 8'h77, "R11 fresh instruction after abort", 32'(v), 32'h77);
    rd1(5'd3, v);
    chk(v == 8'h3C, "R11 aborted byte wrote nothing", 32'(v), 32'h3C);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(4);
    t_reset();
    t_single();
    t_two_wire();
    t_descend();
    t_extra();
    t_ascend();
    t_reserved();
    t_lsb();
    t_three();
    t_next_xfer();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule